// File: doc/BRIEF.md
# Power-On Reset Delay Sequencer

This block produces the active-low reset line for a microcontroller from clean digital supply-status flags. It holds reset low while the regulated output is alive but has not reached its reset threshold. Once the supply is good, it keeps reset low for a further delay, measured in ticks of a free-running time base, before releasing it. The delay length depends on a two-bit mode select: only the all-low code picks the short delay.

A sustained undervoltage, either on the output or on the input, pulls reset low again. Brief dips are filtered by a reaction-time counter that runs on the system clock. A watchdog fault request also drives reset low, and the following release waits for the full delay from zero. When the output is below its minimum operating level, a separate status bit reports that the reset line is not driven. Each release of reset is marked by a one-cycle pulse, so that a watchdog can start its timing cycle from it.

Top module: `rst_release_seq`

## Requirements
- R1: While `sysRst` is high on a clock edge, `rstOutN` and `rstReleased` are 0 after that edge. Any partly counted delay is discarded, so the next release needs the full tick count.
- R2: `rstUndriven` equals the inverse of `supplyAlive`. When `supplyAlive` is 0 on an edge, `rstOutN` is 0 after that edge.
- R3: While `supplyAlive` is 1 and `outAboveThr` is 0, `rstOutN` stays 0 no matter how many ticks arrive.
- R4: With `modeSel == 2'b00` (fast), reset rises on the edge after the edge that counts the FAST_TICKS-th tick with the supply good. FAST_TICKS-1 ticks leave reset low.
- R5: With `modeSel` equal to 2'b01, 2'b10 or 2'b11 (slow), the same rule applies with SLOW_TICKS ticks.
- R6: An undervoltage condition (`outAboveThr` 0 or `inputLow` 1) that is seen on REACT_CYCLES consecutive edges drives `rstOutN` low on the next edge. A shorter run has no effect, and during the delay it does not restart the tick count.
- R7: `inputLow` alone, with `outAboveThr` still 1, is an undervoltage condition under R6.
- R8: `wdFault` high on an edge drives `rstOutN` low after that edge and restarts the delay from zero, whether reset was released or still counting.
- R9: `rstReleased` is high for exactly one cycle, in the first cycle that `rstOutN` is high after being low.
- R10: A tick arriving while the supply is not good (`supplyAlive` 0, `outAboveThr` 0 or `inputLow` 1) is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| sysRst | input | 1 | Synchronous active-high system reset |
| supplyAlive | input | 1 | Output is above the minimum operating level |
| outAboveThr | input | 1 | Output is above the reset threshold |
| inputLow | input | 1 | Input undervoltage flag |
| wdFault | input | 1 | Watchdog fault request |
| modeSel | input | 2 | Reset timing select; 2'b00 is fast, all other codes are slow |
| tbTick | input | 1 | One-cycle time-base tick |
| rstOutN | output | 1 | Active-low reset to the microcontroller |
| rstUndriven | output | 1 | Reset line is not driven (output below minimum level) |
| rstReleased | output | 1 | One-cycle pulse on each release of reset |

## Verification
Two functions can meet in the same cycle: the release of reset at the end of the delay, and an undervoltage dip arriving while the delay is counting. The bench counts part of the delay and then applies a dip one edge shorter than the reaction filter, on the input flag. It then supplies only the remaining ticks. The release pulse must appear in exactly the predicted cycle, which it would not if the dip had restarted the count. A dip of full length, and watchdog faults raised mid-delay, must instead push the release out by a complete fresh delay. The scoreboard judges this by comparing each pulse against the queued expected cycle.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic {
    ST_HOLD = 1'b0,
    ST_RUN  = 1'b1
  } seqState_t;

  typedef struct packed {
    logic clrDelay;
    logic advDelay;
  } dlyStrobe_t;
endpackage

// File: rtl/rstseq_timers.sv
module rstseq_timers
  import rstseq_pkg::*;
#(
  parameter int REACT_CYCLES = 200,
  parameter int FAST_TICKS   = 32,
  parameter int SLOW_TICKS   = 64
) (
  input  logic       clk,
  input  logic       sysRst,
  input  logic       uvRaw,
  input  logic       fastMode,
  input  dlyStrobe_t strobe,
  output logic       uvConfirmed,
  output logic       delayDone
);
  localparam int FLT_W = $clog2(REACT_CYCLES + 1);
  localparam int DLY_W = $clog2(SLOW_TICKS + 1);
  localparam logic [FLT_W-1:0] REACT_MAX = FLT_W'(REACT_CYCLES);
  localparam logic [DLY_W-1:0] FAST_T    = DLY_W'(FAST_TICKS);
  localparam logic [DLY_W-1:0] SLOW_T    = DLY_W'(SLOW_TICKS);

  logic [FLT_W-1:0] filtCnt;
  logic [DLY_W-1:0] delayCnt;
  logic [DLY_W-1:0] target;

  // reaction filter: counts consecutive edges with the undervoltage flag set
  always_ff @(posedge clk) begin
    if (sysRst || !uvRaw) filtCnt <= '0;
    else if (filtCnt != REACT_MAX) filtCnt <= filtCnt + 1'b1;
  end

  assign uvConfirmed = (filtCnt == REACT_MAX);

  // release delay in time-base ticks
  always_ff @(posedge clk) begin
    if (sysRst || strobe.clrDelay) delayCnt <= '0;
    else if (strobe.advDelay)      delayCnt <= delayCnt + 1'b1;
  end

  assign target    = fastMode ? FAST_T : SLOW_T;
  assign delayDone = (delayCnt >= target);

  // R6
  no_filter_overrun_chk: assert property (@(posedge clk) disable iff (sysRst)
    filtCnt <= REACT_MAX);

  // R5
  no_delay_overrun_chk: assert property (@(posedge clk) disable iff (sysRst)
    delayCnt <= SLOW_T);
endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
  import rstseq_pkg::*;
(
  input  logic       clk,
  input  logic       sysRst,
  input  logic       supplyAlive,
  input  logic       supplyGood,
  input  logic       wdFault,
  input  logic       tbTick,
  input  logic       uvConfirmed,
  input  logic       delayDone,
  output dlyStrobe_t strobe,
  output logic       rstOutN,
  output logic       rstReleased
);
  seqState_t state, nextState;
  logic kill;

  assign kill = !supplyAlive || uvConfirmed || wdFault;

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_HOLD: begin
        if (kill)                          strobe.clrDelay = 1'b1;
        else if (delayDone && supplyGood)  nextState       = ST_RUN;
        else if (tbTick && supplyGood)     strobe.advDelay = 1'b1;
      end
      ST_RUN: begin
        strobe.clrDelay = 1'b1;
        if (kill) nextState = ST_HOLD;
      end
      default: nextState = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (sysRst) begin
      state       <= ST_HOLD;
      rstReleased <= 1'b0;
    end else begin
      state       <= nextState;
      rstReleased <= (state == ST_HOLD) && (nextState == ST_RUN);
    end
  end

  assign rstOutN = (state == ST_RUN);

  // R9
  pulse_with_release_chk: assert property (@(posedge clk) disable iff (sysRst)
    rstReleased |-> (rstOutN && !$past(rstOutN)));

  // R9
  release_has_pulse_chk: assert property (@(posedge clk) disable iff (sysRst)
    $rose(rstOutN) |-> rstReleased);

  // R4
  release_after_delay_chk: assert property (@(posedge clk) disable iff (sysRst)
    $rose(rstOutN) |-> $past(delayDone));

  // R2
  dead_supply_low_chk: assert property (@(posedge clk) disable iff (sysRst)
    !supplyAlive |=> !rstOutN);

  // R6
  uv_forces_low_chk: assert property (@(posedge clk) disable iff (sysRst)
    uvConfirmed |=> !rstOutN);

  // R8
  wd_forces_low_chk: assert property (@(posedge clk) disable iff (sysRst)
    wdFault |=> !rstOutN);
endmodule

// File: rtl/rst_release_seq.sv
module rst_release_seq
  import rstseq_pkg::*;
#(
  parameter int REACT_CYCLES = 200,
  parameter int FAST_TICKS   = 32,
  parameter int SLOW_TICKS   = 64
) (
  input  logic       clk,
  input  logic       sysRst,
  input  logic       supplyAlive,
  input  logic       outAboveThr,
  input  logic       inputLow,
  input  logic       wdFault,
  input  logic [1:0] modeSel,
  input  logic       tbTick,
  output logic       rstOutN,
  output logic       rstUndriven,
  output logic       rstReleased
);
  dlyStrobe_t strobe;
  logic uvRaw, supplyGood, fastMode, uvConfirmed, delayDone;

  assign uvRaw       = !outAboveThr || inputLow;
  assign supplyGood  = supplyAlive && outAboveThr && !inputLow;
  assign fastMode    = (modeSel == 2'b00);
  assign rstUndriven = !supplyAlive;

  rstseq_timers #(
    .REACT_CYCLES(REACT_CYCLES),
    .FAST_TICKS  (FAST_TICKS),
    .SLOW_TICKS  (SLOW_TICKS)
  ) u_timers (
    .clk        (clk),
    .sysRst     (sysRst),
    .uvRaw      (uvRaw),
    .fastMode   (fastMode),
    .strobe     (strobe),
    .uvConfirmed(uvConfirmed),
    .delayDone  (delayDone)
  );

  rstseq_ctrl u_ctrl (
    .clk        (clk),
    .sysRst     (sysRst),
    .supplyAlive(supplyAlive),
    .supplyGood (supplyGood),
    .wdFault    (wdFault),
    .tbTick     (tbTick),
    .uvConfirmed(uvConfirmed),
    .delayDone  (delayDone),
    .strobe     (strobe),
    .rstOutN    (rstOutN),
    .rstReleased(rstReleased)
  );
endmodule

// File: tb/rst_release_seq_tb.sv
`timescale 1ns/1ps
module rst_release_seq_tb;
  localparam int REACT = 8;
  localparam int FAST  = 4;
  localparam int SLOW  = 8;

  logic clk = 1'b0;
  logic sysRst = 1'b1;
  logic supplyAlive = 1'b0, outAboveThr = 1'b0, inputLow = 1'b0, wdFault = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic tbTick = 1'b0;
  logic rstOutN, rstUndriven, rstReleased;

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  int expQ[$];
  bit prevRel = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rst_release_seq #(.REACT_CYCLES(REACT), .FAST_TICKS(FAST), .SLOW_TICKS(SLOW)) u_dut (
    .clk(clk), .sysRst(sysRst), .supplyAlive(supplyAlive), .outAboveThr(outAboveThr),
    .inputLow(inputLow), .wdFault(wdFault), .modeSel(modeSel), .tbTick(tbTick),
    .rstOutN(rstOutN), .rstUndriven(rstUndriven), .rstReleased(rstReleased));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: issues ticks and queues the expected release cycle
  task automatic giveTicks(input int n, input bit expectRel);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tbTick = 1'b1;
      @(negedge clk); tbTick = 1'b0;
      if (expectRel && i == n - 1) expQ.push_back(cyc + 1);
      @(negedge clk);
    end
  endtask

  task automatic dip(input bit onInput, input int edges);
    @(negedge clk);
    if (onInput) inputLow = 1'b1; else outAboveThr = 1'b0;
    repeat (edges) @(posedge clk);
    @(negedge clk);
    inputLow = 1'b0; outAboveThr = 1'b1;
  endtask

  task automatic pulseWd();
    @(negedge clk); wdFault = 1'b1;
    @(negedge clk); wdFault = 1'b0;
  endtask

  // monitor: pops the scoreboard on every release pulse
  always @(negedge clk) begin
    if (!sysRst && rstReleased) begin
      if (expQ.size() == 0) check(1'b0, "R9 unexpected release", 1, 0);
      else begin
        int e;
        e = expQ.pop_front();
        check(cyc == e, "R4/R5 release cycle", cyc, e);
      end
      check(rstOutN == 1'b1, "R9 reset high with pulse", rstOutN, 1);
      check(!prevRel, "R9 pulse one cycle", 2, 1);
    end
    prevRel = rstReleased;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    waitCyc(3);
    check(rstOutN == 0 && rstReleased == 0, "R1 reset state", rstOutN, 0);
    sysRst = 1'b0;
    waitCyc(2);
    check(rstUndriven == 1, "R2 undriven while dead", rstUndriven, 1);
    giveTicks(6, 0);
    check(rstOutN == 0, "R10 dead supply ticks ignored", rstOutN, 0);

    supplyAlive = 1'b1;
    waitCyc(1);
    check(rstUndriven == 0, "R2 driven when alive", rstUndriven, 0);
    giveTicks(10, 0);
    check(rstOutN == 0, "R3 below threshold held low", rstOutN, 0);

    // fast release
    outAboveThr = 1'b1;
    waitCyc(2);
    giveTicks(FAST - 1, 0);
    check(rstOutN == 0, "R4 fast short of delay", rstOutN, 0);
    giveTicks(1, 1);
    waitCyc(2);
    check(rstOutN == 1, "R4 fast released", rstOutN, 1);

    // short and full output dips while released
    dip(1'b0, REACT - 1);
    waitCyc(3);
    check(rstOutN == 1, "R6 short dip ignored", rstOutN, 1);
    dip(1'b0, REACT);
    waitCyc(1);
    check(rstOutN == 0, "R6 sustained dip resets", rstOutN, 0);

    // short input dip mid-delay does not restart the count
    waitCyc(2);
    giveTicks(2, 0);
    dip(1'b1, REACT - 1);
    waitCyc(3);
    check(rstOutN == 0, "R6 still counting", rstOutN, 0);
    giveTicks(2, 1);
    waitCyc(2);
    check(rstOutN == 1, "R6 count kept over short dip", rstOutN, 1);

    // input undervoltage alone, then slow release with code 10
    modeSel = 2'b10;
    dip(1'b1, REACT);
    waitCyc(1);
    check(rstOutN == 0, "R7 input undervoltage resets", rstOutN, 0);
    waitCyc(2);
    giveTicks(SLOW - 1, 0);
    check(rstOutN == 0, "R5 slow short of delay (10)", rstOutN, 0);
    giveTicks(1, 1);
    waitCyc(2);
    check(rstOutN == 1, "R5 slow released (10)", rstOutN, 1);

    // watchdog fault while released, code 01
    modeSel = 2'b01;
    pulseWd();
    check(rstOutN == 0, "R8 watchdog resets", rstOutN, 0);
    giveTicks(SLOW - 1, 0);
    check(rstOutN == 0, "R5 slow short of delay (01)", rstOutN, 0);
    giveTicks(1, 1);
    waitCyc(2);
    check(rstOutN == 1, "R5 slow released (01)", rstOutN, 1);

    // watchdog fault mid-delay restarts from zero, code 11
    modeSel = 2'b11;
    pulseWd();
    giveTicks(5, 0);
    pulseWd();
    giveTicks(SLOW - 1, 0);
    check(rstOutN == 0, "R8 delay restarted", rstOutN, 0);
    giveTicks(1, 1);
    waitCyc(2);
    check(rstOutN == 1, "R8 released after full delay", rstOutN, 1);

    // system reset mid-delay discards the count
    modeSel = 2'b00;
    pulseWd();
    giveTicks(3, 0);
    @(negedge clk); sysRst = 1'b1;
    @(negedge clk); sysRst = 1'b0;
    check(rstOutN == 0 && rstReleased == 0, "R1 sync reset low", rstOutN, 0);
    giveTicks(FAST - 1, 0);
    check(rstOutN == 0, "R1 count cleared", rstOutN, 0);
    giveTicks(1, 1);
    waitCyc(2);
    check(rstOutN == 1, "R1 full delay after reset", rstOutN, 1);

    // supply collapse from released state
    @(negedge clk); supplyAlive = 1'b0;
    @(negedge clk);
    check(rstOutN == 0, "R2 collapse resets", rstOutN, 0);
    check(rstUndriven == 1, "R2 undriven on collapse", rstUndriven, 1);
    supplyAlive = 1'b1;
    waitCyc(2);
    giveTicks(FAST, 1);
    waitCyc(2);
    check(rstOutN == 1, "R4 released after collapse", rstOutN, 1);

    waitCyc(4);
    check(expQ.size() == 0, "R9 all releases seen", expQ.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule